// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog driven by a 16 Hz tick. Software arms it by writing one byte to its control register. The byte holds three fields: a 5-bit multiplier, a 2-bit resolution code that scales the multiplier by 1, 4, 16 or 64 ticks, and a steer bit. The steer bit chooses what happens at expiry. With steer set, the block raises a system-reset request. With steer clear, it raises an interrupt pulse.

Every access to the control register restarts the countdown from the value currently stored, whether the access is a write or a read. Software therefore services the watchdog by reading the register it set up. Each restart clears the timeout flag, and every expiry sets it.

On a reset-steered expiry the block also clears the control register to zero, which disarms it. In the same step it clears bit 6 of a companion byte register that sits beside the watchdog. The register port is a plain one-cycle strobe, because no data stream passes through this block.

Top module: `enc_watchdog`

## Requirements
- R1: After reset the control register, the flag and the companion register read 0. `irq_o` and `sys_rst_req_o` are low, and no expiry occurs however many ticks arrive.
- R2: The control byte is laid out as bit 7 steer, bits 6:2 multiplier M and bits 1:0 resolution code R. After a restart, the expiry takes effect on the M·4^R-th tick, counting the tick in the restart cycle as none. The output pulse is high in the clock cycle that follows that tick's edge.
- R3: A multiplier of 0, whatever R and steer are, leaves the watchdog stopped. Writing 0 while a countdown is running also stops it, and no expiry follows.
- R4: An access strobe with `acc_sel_i`=0 and `acc_wr_i`=0 (a read of the control register) restarts the countdown from the stored value.
- R5: Every restart clears the flag. The flag is visible as `wd_flag_o` and as bit 7 of the flags register (`acc_sel_i`=1).
- R6: An expiry sets the flag, and the flag stays set until the next restart.
- R7: An expiry with steer=1 gives a one-cycle `sys_rst_req_o` pulse with `irq_o` low. In that cycle the control register reads 0 and bit 6 of the companion register (`acc_sel_i`=2) is 0, with its other bits unchanged.
- R8: An expiry with steer=0 gives a one-cycle `irq_o` pulse with `sys_rst_req_o` low. The control register keeps its value, and no further expiry occurs until a restart.
- R9: When a restart and the expiring tick fall in the same cycle, the restart wins. No pulse is produced, the flag stays clear, and a fresh full countdown begins.
- R10: Writes to the flags register (`acc_sel_i`=1) are ignored. Select code 3 reads 0 and ignores writes. Companion-register writes do not restart the watchdog.
- R11: A read strobe returns its data on `acc_rdata_o` in the clock cycle after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe at 16 Hz |
| acc_en_i | input | 1 | Register access strobe |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 2 | 0 control, 1 flags, 2 companion, 3 none |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry |
| sys_rst_req_o | output | 1 | One-cycle system-reset request on expiry |
| wd_flag_o | output | 1 | Timeout flag |

## Verification
The two functions that can meet in one cycle are a restart, caused by a read or write of the control register, and the tick that would end the countdown. The bench arms a one-tick interval and then drives the tick together with a control-register read in the same cycle. It judges the result by the absence of any pulse, a clear flag, and a full new interval counted afterwards. A second collision puts a companion-register write in the same cycle as a reset-steered expiry, which shows whether the write or the forced clear of bit 6 lands.

// File: rtl/enc_wdog_pkg.sv
package enc_wdog_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_FLAGS = 2'd1,
    SEL_AUX   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // bit of the companion register cleared by a reset-steered expiry
  localparam int AUX_CLR_BIT = 6;
endpackage

// File: rtl/wdog_interval_dec.sv
module wdog_interval_dec #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = 11
) (
  input  logic [MULT_W+RES_W-1:0] field_i,
  output logic [CNT_W-1:0]        load_o
);
  localparam int STEPS = 1 << RES_W;

  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic [CNT_W-1:0]  scaled [STEPS];

  assign mult = field_i[MULT_W+RES_W-1:RES_W];
  assign res  = field_i[RES_W-1:0];

  for (genvar g = 0; g < STEPS; g++) begin : g_scale
    assign scaled[g] = CNT_W'(mult) << (2 * g);
  end

  assign load_o = scaled[res];
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             expire_o,
  output logic             running_o
);
  logic [CNT_W-1:0] cnt_q;

  assign running_o = (cnt_q != '0);
  assign expire_o  = tick_i && (cnt_q == CNT_W'(1)) && !restart_i;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart_i)
      cnt_q <= load_i;
    else if (tick_i && running_o)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  // R3
  zero_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && load_i == '0) |=> !running_o);

  // R8
  stop_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !running_o);

  // R2
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && running_o) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/wdog_regbank.sv
module wdog_regbank
  import enc_wdog_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [1:0]        acc_sel_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic              expire_i,
  output logic              restart_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int STEER = DATA_W - 1;

  logic [DATA_W-1:0] ctrl_q, aux_q, aux_nxt;
  logic              flag_q, irq_q, rst_q;
  logic              wr_ctrl, wr_aux, steer_exp;
  reg_sel_e          sel;

  assign sel       = reg_sel_e'(acc_sel_i);
  assign restart_o = acc_en_i && (sel == SEL_CTRL);
  assign wr_ctrl   = acc_en_i && acc_wr_i && (sel == SEL_CTRL);
  assign wr_aux    = acc_en_i && acc_wr_i && (sel == SEL_AUX);
  assign steer_exp = expire_i && ctrl_q[STEER];

  always_comb begin
    aux_nxt = wr_aux ? acc_wdata_i : aux_q;
    if (steer_exp) aux_nxt[AUX_CLR_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      aux_q   <= '0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      irq_q <= expire_i && !ctrl_q[STEER];
      rst_q <= steer_exp;
      aux_q <= aux_nxt;
      if (restart_o)     flag_q <= 1'b0;
      else if (expire_i) flag_q <= 1'b1;
      if (wr_ctrl)        ctrl_q <= acc_wdata_i;
      else if (steer_exp) ctrl_q <= '0;
      if (acc_en_i && !acc_wr_i) begin
        unique case (sel)
          SEL_CTRL:  rdata_o <= ctrl_q;
          SEL_FLAGS: rdata_o <= {flag_q, {(DATA_W-1){1'b0}}};
          SEL_AUX:   rdata_o <= aux_q;
          default:   rdata_o <= '0;
        endcase
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R7
  one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, rst_q}));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> flag_q);

  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !flag_q);

  // R7
  steer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (ctrl_q == '0 && !aux_q[AUX_CLR_BIT]));

  // R9
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !(irq_q || rst_q));

  // R10
  flags_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && acc_wr_i && sel == SEL_FLAGS && !expire_i) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/enc_watchdog.sv
module enc_watchdog #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       acc_en_i,
  input  logic       acc_wr_i,
  input  logic [1:0] acc_sel_i,
  input  logic [7:0] acc_wdata_i,
  output logic [7:0] acc_rdata_o,
  output logic       irq_o,
  output logic       sys_rst_req_o,
  output logic       wd_flag_o
);
  localparam int FIELD_W = MULT_W + RES_W;
  localparam int DATA_W  = FIELD_W + 1;
  localparam int CNT_W   = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [DATA_W-1:0]  ctrl, rdata;
  logic [FIELD_W-1:0] field;
  logic [CNT_W-1:0]   load;
  logic               restart, expire, running;

  // a write reloads from the incoming byte, a read from the stored one
  assign field = acc_wr_i ? acc_wdata_i[FIELD_W-1:0] : ctrl[FIELD_W-1:0];

  wdog_interval_dec #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_dec (
    .field_i (field),
    .load_o  (load)
  );

  wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .load_i    (load),
    .tick_i    (tick_i),
    .expire_o  (expire),
    .running_o (running)
  );

  wdog_regbank #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_en_i    (acc_en_i),
    .acc_wr_i    (acc_wr_i),
    .acc_sel_i   (acc_sel_i),
    .acc_wdata_i (acc_wdata_i[DATA_W-1:0]),
    .expire_i    (expire),
    .restart_o   (restart),
    .ctrl_o      (ctrl),
    .flag_o      (wd_flag_o),
    .rdata_o     (rdata),
    .irq_o       (irq_o),
    .rst_req_o   (sys_rst_req_o)
  );

  assign acc_rdata_o = 8'(rdata);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart) |=> !(irq_o || sys_rst_req_o));
endmodule

// File: tb/sim_enc_watchdog.sv
module sim_enc_watchdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, en = 1'b0, wr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, rreq, flag;
  int         checks = 0, fails = 0;

  always #5 clk = ~clk;

  enc_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .acc_en_i(en), .acc_wr_i(wr),
    .acc_sel_i(sel), .acc_wdata_i(wdata), .acc_rdata_o(rdata),
    .irq_o(irq), .sys_rst_req_o(rreq), .wd_flag_o(flag)
  );

  function automatic int exp_ticks(input logic [7:0] b);
    return int'(b[6:2]) << (2 * int'(b[1:0]));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    en = 1'b1; wr = w; sel = s; wdata = d;
    @(posedge clk); #1;
    en = 1'b0; wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    access(1'b0, s, 8'd0);
    v = rdata;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1; tick = 1'b0;
  endtask

  // ticks until a pulse shows; n = 0 if none within max
  task automatic run_ticks(input int max, output int n, output bit si, output bit sr);
    n = 0; si = 0; sr = 0;
    for (int i = 1; i <= max; i++) begin
      one_tick();
      if (irq || rreq) begin
        n = i; si = irq; sr = rreq;
        return;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, b;
    int n, e;
    bit si, sr;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 flags", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 aux", v, 0);
    chk(!irq && !rreq && !flag, "R1 outputs", {irq, rreq, flag}, 0);
    run_ticks(20, n, si, sr); chk(n == 0, "R1 no expiry", n, 0);

    // R2 R7 R8 random intervals and steer
    for (int t = 0; t < 8; t++) begin
      b = {1'($urandom_range(1)), 5'($urandom_range(31, 1)), 2'($urandom_range(2))};
      e = exp_ticks(b);
      access(1'b1, 2'd2, 8'hFF);
      access(1'b1, 2'd0, b);
      run_ticks(e + 2, n, si, sr);
      chk(n == e, "R2 interval", n, e);
      chk(si == !b[7] && sr == b[7], "R7 R8 cause", {si, sr}, {!b[7], b[7]});
      @(posedge clk); #1;
      chk(!irq && !rreq, "R7 R8 single cycle pulse", {irq, rreq}, 0);
      chk(flag, "R6 flag set", flag, 1);
      rd(2'd1, v); chk(v == 8'h80, "R6 flags bit7", v, 8'h80);
      rd(2'd2, v); chk(v == (b[7] ? 8'hBF : 8'hFF), "R7 aux bit6", v, b[7] ? 8'hBF : 8'hFF);
      if (!b[7]) begin
        rd(2'd0, v); chk(v == b, "R8 ctrl kept", v, b);
        access(1'b1, 2'd0, 8'h00);
      end else begin
        rd(2'd0, v); chk(v == 0, "R7 ctrl cleared", v, 0);
      end
    end

    // R2 largest resolution, small multiplier: 1*64
    access(1'b1, 2'd0, 8'h07);
    run_ticks(70, n, si, sr); chk(n == 64 && si, "R2 res3", n, 64);
    // R8 stopped after interrupt expiry
    run_ticks(70, n, si, sr); chk(n == 0, "R8 no rearm", n, 0);
    chk(flag, "R6 flag holds", flag, 1);

    // R5 restart clears flag, R4 read restarts
    access(1'b1, 2'd0, 8'h05);            // M=1 R=1 -> 4 ticks
    chk(!flag, "R5 flag cleared", flag, 0);
    for (int i = 0; i < 3; i++) one_tick();
    rd(2'd0, v); chk(v == 8'h05, "R4 read value", v, 8'h05);
    run_ticks(8, n, si, sr); chk(n == 4, "R4 read restart", n, 4);

    // R3 zero multiplier variants and stop by writing 0
    access(1'b1, 2'd0, 8'h83);
    run_ticks(80, n, si, sr); chk(n == 0 && !flag, "R3 mult zero", n, 0);
    access(1'b1, 2'd0, 8'h09);            // 8 ticks
    for (int i = 0; i < 4; i++) one_tick();
    access(1'b1, 2'd0, 8'h00);
    run_ticks(20, n, si, sr); chk(n == 0, "R3 stop by zero", n, 0);

    // R9 restart and expiring tick in the same cycle
    access(1'b1, 2'd0, 8'h04);            // 1 tick
    @(negedge clk); tick = 1'b1; en = 1'b1; wr = 1'b0; sel = 2'd0;
    @(posedge clk); #1; tick = 1'b0; en = 1'b0;
    chk(!irq && !rreq && !flag, "R9 restart wins", {irq, rreq, flag}, 0);
    run_ticks(4, n, si, sr); chk(n == 1, "R9 fresh interval", n, 1);

    // R9 companion write meets reset-steered expiry
    access(1'b1, 2'd0, 8'h84);
    @(negedge clk); tick = 1'b1; en = 1'b1; wr = 1'b1; sel = 2'd2; wdata = 8'hFF;
    @(posedge clk); #1; tick = 1'b0; en = 1'b0; wr = 1'b0;
    chk(rreq, "R9 expiry with aux write", rreq, 1);
    rd(2'd2, v); chk(v == 8'hBF, "R9 aux clear wins", v, 8'hBF);

    // R10 read-only flags, unused select, aux write no restart
    chk(flag, "R10 flag before", flag, 1);
    access(1'b1, 2'd1, 8'h00);
    rd(2'd1, v); chk(v == 8'h80, "R10 flags write ignored", v, 8'h80);
    access(1'b1, 2'd3, 8'hAA);
    rd(2'd3, v); chk(v == 0, "R10 unused select", v, 0);
    access(1'b1, 2'd2, 8'h12);
    chk(flag, "R10 aux write no restart", flag, 1);
    // R11 latency: data present right after strobe edge
    rd(2'd2, v); chk(v == 8'h12, "R11 read latency", v, 8'h12);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule